// File: doc/BRIEF.md
# Programmable Clock Output Pair Selector

This block sits behind a PLL and produces a set of output clock pairs. Each pair has a 3-bit source code. The code routes the pair to the raw reference clock, to the PLL clock divided by 1, 2, 3 or 4, or to a divider whose ratio is set at run time (X, or twice X). It can also route the pair to a static level that reports PLL lock. Every single output has its own inversion control. The pairs form two equal banks. Bank A holds pairs 0 to PAIRS_PER_BANK-1 and bank B holds the remainder.

A two-pin mode input is decoded by a small state machine clocked on the PLL clock. The machine decides which banks are enabled. It also decides whether the divider taps come from the PLL clock or from the reference clock (bypass). Three-state is modelled as one enable signal per bank. The drive pins themselves are not part of this block.

The state machine has four states:
- ST_DARK: both banks disabled, PLL taps. This is the reset state.
- ST_A_LIVE: bank A enabled, PLL taps.
- ST_REF_BYPASS: both banks enabled, reference taps.
- ST_PLL_ALL: both banks enabled, PLL taps.

There is a single transition, LOAD. On every PLL clock edge outside reset, the machine moves to the state that the pins currently encode. A synchronous reset forces ST_DARK.

The divider counters in each clock domain are cleared together by the synchronous reset. As a result, outputs that share a setting start in phase.

Top module: `clk_pair_sel`

## Requirements
- R1: In PLL mode, source codes 001, 010, 011 and 100 give the PLL clock divided by 1, 2, 3 and 4.
- R2: Every divided output with divisor D has a period of 2D half-cycles and is high for the first D half-cycles of each period. The phase is counted from the first rising edge of its source clock after reset is released. For D=1 this means the output equals the source clock.
- R3: Source code 000 gives the reference clock itself, in every mode.
- R4: Source code 111 drives each output of the pair to the lock input XOR that output's inversion bit.
- R5: When an output's inversion bit (bit 2p+j of out_inv, for pair p and output j) is 1, that output is the complement of its selected source, for every source code.
- R6: Code 101 divides by X and code 110 divides by 2X. Any X below 2 acts as 2.
- R7: On each PLL clock edge outside reset, the banks are enabled from mode_sel: 00 gives neither, 01 gives bank A only, 10 and 11 give both. The enables change only at that edge, and bank B is never enabled while bank A is disabled.
- R8: With mode_sel=10, codes 001 to 110 divide the reference clock instead of the PLL clock.
- R9: While reset is held, both bank enables are low and every output with code 010 to 110 is at its inversion level.
- R10: Outputs with the same source code and the same inversion bit are identical at all times, within a pair and across pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pll_clk | input | 1 | High-rate PLL clock; also clocks the mode state machine |
| ref_clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high, sampled in each clock domain |
| pll_lock | input | 1 | PLL lock flag |
| mode_sel | input | 2 | Bank enable and bypass mode |
| div_x | input | XW | Programmable divisor X |
| pair_src | input | 3*2*PAIRS_PER_BANK | Source code of pair p at bits 3p+2..3p |
| out_inv | input | 2*2*PAIRS_PER_BANK | Inversion bit of output j of pair p at bit 2p+j |
| clk_out | output | 2*2*PAIRS_PER_BANK | Output j of pair p at bit 2p+j |
| oe_a | output | 1 | Bank A enable |
| oe_b | output | 1 | Bank B enable |

## Verification
The assertions check four things on every PLL edge. First, lock-indicator outputs track the lock flag and their inversion bit. Second, the bank enables follow the mode pins with one edge of delay. Third, bank B is never enabled without bank A. Fourth, a divide-by-2 output in PLL mode toggles on every edge.

The duty cycle, the phase at which each divider starts after reset, the clamping of X, reference bypass and alignment between pairs can only be shown by the bench's sweeps. These sweeps predict every output at every half-cycle from the divisor alone, across several code assignments and both clock domains.

// File: rtl/clk_pair_pkg.sv
package clk_pair_pkg;

    typedef enum logic [2:0] {
        SRC_REF  = 3'b000,
        SRC_D1   = 3'b001,
        SRC_D2   = 3'b010,
        SRC_D3   = 3'b011,
        SRC_D4   = 3'b100,
        SRC_DX   = 3'b101,
        SRC_D2X  = 3'b110,
        SRC_LOCK = 3'b111
    } src_code_e;

    typedef enum logic [1:0] {
        ST_DARK       = 2'd0,
        ST_A_LIVE     = 2'd1,
        ST_REF_BYPASS = 2'd2,
        ST_PLL_ALL    = 2'd3
    } bank_state_e;

    typedef struct packed {
        logic d1;
        logic d2;
        logic d3;
        logic d4;
        logic dx;
        logic d2x;
    } tap_set_t;

endpackage

// File: rtl/clk_div_core.sv
// Integer divider: high for the first D half-cycles of every 2D half-cycle period.
// Odd divisors extend the high phase by half a cycle with a falling-edge stage.
module clk_div_core #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] divisor,
    output logic          div_out
);

    logic [DW-1:0] cnt;
    logic [DW-1:0] cnt_nxt;
    logic          rise_q;
    logic          fall_q;

    always_comb begin
        if (cnt >= divisor - DW'(1)) begin
            cnt_nxt = '0;
        end else begin
            cnt_nxt = cnt + DW'(1);
        end
    end

    // Reset parks the counter on its last value so the first edge starts a period.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= divisor - DW'(1);
            rise_q <= 1'b0;
        end else begin
            cnt    <= cnt_nxt;
            rise_q <= (cnt_nxt < (divisor >> 1));
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= rise_q;
        end
    end

    assign div_out = divisor[0] ? (rise_q | fall_q) : rise_q;

endmodule

// File: rtl/clk_div_bank.sv
// One set of divider taps in one clock domain.
module clk_div_bank
    import clk_pair_pkg::*;
#(
    parameter int XW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [XW-1:0] x_div,
    output tap_set_t      taps
);

    localparam int DW    = XW + 1;
    localparam int NCORE = 5;

    logic [NCORE-1:0] core_out;

    for (genvar i = 0; i < NCORE; i++) begin : g_core
        logic [DW-1:0] dv;
        if (i < 3) begin : g_fixed
            assign dv = DW'(i + 2);
        end else if (i == 3) begin : g_x
            assign dv = {1'b0, x_div};
        end else begin : g_2x
            assign dv = {x_div, 1'b0};
        end
        clk_div_core #(.DW(DW)) u_core (
            .clk     (clk),
            .rst     (rst),
            .divisor (dv),
            .div_out (core_out[i])
        );
    end

    always_comb begin
        taps.d1  = clk;
        taps.d2  = core_out[0];
        taps.d3  = core_out[1];
        taps.d4  = core_out[2];
        taps.dx  = core_out[3];
        taps.d2x = core_out[4];
    end

endmodule

// File: rtl/clk_mode_fsm.sv
// Bank enable and bypass state machine, loaded from the mode pins every edge.
module clk_mode_fsm
    import clk_pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_pins,
    output logic       en_a,
    output logic       en_b,
    output logic       use_ref
);

    bank_state_e state;
    bank_state_e state_nxt;

    always_comb begin
        unique case (mode_pins)
            2'b00:   state_nxt = ST_DARK;
            2'b01:   state_nxt = ST_A_LIVE;
            2'b10:   state_nxt = ST_REF_BYPASS;
            default: state_nxt = ST_PLL_ALL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_DARK;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        en_a    = 1'b0;
        en_b    = 1'b0;
        use_ref = 1'b0;
        unique case (state)
            ST_DARK: begin
                en_a = 1'b0;
                en_b = 1'b0;
            end
            ST_A_LIVE: begin
                en_a = 1'b1;
            end
            ST_REF_BYPASS: begin
                en_a    = 1'b1;
                en_b    = 1'b1;
                use_ref = 1'b1;
            end
            ST_PLL_ALL: begin
                en_a = 1'b1;
                en_b = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/clk_pair_mux.sv
// Per-pair source selection and per-output inversion.
module clk_pair_mux
    import clk_pair_pkg::*;
(
    input  logic [2:0] code,
    input  logic [1:0] inv,
    input  tap_set_t   pll_taps,
    input  tap_set_t   ref_taps,
    input  logic       ref_clk,
    input  logic       use_ref,
    input  logic       lock,
    output logic [1:0] pair_out
);

    tap_set_t t;
    logic     base;

    assign t = use_ref ? ref_taps : pll_taps;

    always_comb begin
        base = 1'b0;
        unique case (src_code_e'(code))
            SRC_REF:  base = ref_clk;
            SRC_D1:   base = t.d1;
            SRC_D2:   base = t.d2;
            SRC_D3:   base = t.d3;
            SRC_D4:   base = t.d4;
            SRC_DX:   base = t.dx;
            SRC_D2X:  base = t.d2x;
            SRC_LOCK: base = lock;
        endcase
    end

    assign pair_out = {2{base}} ^ inv;

endmodule

// File: rtl/clk_pair_sel.sv
module clk_pair_sel
    import clk_pair_pkg::*;
#(
    parameter int PAIRS_PER_BANK = 3,
    parameter int XW             = 8
) (
    input  logic                          pll_clk,
    input  logic                          ref_clk,
    input  logic                          rst,
    input  logic                          pll_lock,
    input  logic [1:0]                    mode_sel,
    input  logic [XW-1:0]                 div_x,
    input  logic [3*2*PAIRS_PER_BANK-1:0] pair_src,
    input  logic [2*2*PAIRS_PER_BANK-1:0] out_inv,
    output logic [2*2*PAIRS_PER_BANK-1:0] clk_out,
    output logic                          oe_a,
    output logic                          oe_b
);

    localparam int NPAIR = 2 * PAIRS_PER_BANK;

    logic [XW-1:0] x_eff;
    tap_set_t      pll_taps;
    tap_set_t      ref_taps;
    logic          use_ref;

    assign x_eff = (div_x < XW'(2)) ? XW'(2) : div_x;

    clk_mode_fsm u_fsm (
        .clk       (pll_clk),
        .rst       (rst),
        .mode_pins (mode_sel),
        .en_a      (oe_a),
        .en_b      (oe_b),
        .use_ref   (use_ref)
    );

    clk_div_bank #(.XW(XW)) u_pll_bank (
        .clk   (pll_clk),
        .rst   (rst),
        .x_div (x_eff),
        .taps  (pll_taps)
    );

    clk_div_bank #(.XW(XW)) u_ref_bank (
        .clk   (ref_clk),
        .rst   (rst),
        .x_div (x_eff),
        .taps  (ref_taps)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        clk_pair_mux u_mux (
            .code     (pair_src[3*p +: 3]),
            .inv      (out_inv[2*p +: 2]),
            .pll_taps (pll_taps),
            .ref_taps (ref_taps),
            .ref_clk  (ref_clk),
            .use_ref  (use_ref),
            .lock     (pll_lock),
            .pair_out (clk_out[2*p +: 2])
        );
    end

endmodule

// File: rtl/clk_pair_sel_chk.sv
module clk_pair_sel_chk #(
    parameter int PAIRS_PER_BANK = 3
) (
    input logic                          pll_clk,
    input logic                          rst,
    input logic                          pll_lock,
    input logic [1:0]                    mode_sel,
    input logic [3*2*PAIRS_PER_BANK-1:0] pair_src,
    input logic [2*2*PAIRS_PER_BANK-1:0] out_inv,
    input logic [2*2*PAIRS_PER_BANK-1:0] clk_out,
    input logic                          oe_a,
    input logic                          oe_b
);

    localparam int NPAIR = 2 * PAIRS_PER_BANK;

    logic armed1 = 1'b0;
    logic armed2 = 1'b0;

    always_ff @(posedge pll_clk) begin
        armed1 <= !rst;
        armed2 <= armed1 && !rst;
    end

    // R7: enables reflect the pins sampled on the previous edge
    a_r7_mode_follow: assert property (@(posedge pll_clk) disable iff (rst)
        armed1 |-> (oe_a == ($past(mode_sel) != 2'b00)) &&
                   (oe_b == $past(mode_sel[1])));

    // R7: bank B never enabled alone
    a_r7_b_needs_a: assert property (@(posedge pll_clk) disable iff (rst)
        oe_b |-> oe_a);

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        for (genvar j = 0; j < 2; j++) begin : g_side
            // R4: lock indicator level with inversion
            a_r4_lock_level: assert property (@(posedge pll_clk) disable iff (rst)
                (pair_src[3*p +: 3] == 3'b111) |->
                    (clk_out[2*p+j] == (pll_lock ^ out_inv[2*p+j])));
        end

        // R1: divide-by-2 in PLL mode changes level on every PLL edge
        a_r1_div2_toggle: assert property (@(posedge pll_clk) disable iff (rst)
            (armed2 && mode_sel == 2'b11 && $past(mode_sel) == 2'b11 &&
             $past(mode_sel, 2) == 2'b11 && pair_src[3*p +: 3] == 3'b010 &&
             $stable(pair_src[3*p +: 3]) && $stable(out_inv[2*p])) |->
                (clk_out[2*p] != $past(clk_out[2*p])));
    end

endmodule

bind clk_pair_sel clk_pair_sel_chk #(.PAIRS_PER_BANK(PAIRS_PER_BANK)) u_chk (
    .pll_clk  (pll_clk),
    .rst      (rst),
    .pll_lock (pll_lock),
    .mode_sel (mode_sel),
    .pair_src (pair_src),
    .out_inv  (out_inv),
    .clk_out  (clk_out),
    .oe_a     (oe_a),
    .oe_b     (oe_b)
);

// File: tb/test_clk_pair_sel.sv
module test_clk_pair_sel;

    localparam int PPB = 3;
    localparam int NP  = 2 * PPB;
    localparam int XW  = 8;

    logic              pll_clk  = 1'b0;
    logic              ref_clk  = 1'b0;
    logic              rst      = 1'b1;
    logic              pll_lock = 1'b0;
    logic [1:0]        mode_sel = 2'b11;
    logic [XW-1:0]     div_x    = 8'd3;
    logic [3*NP-1:0]   pair_src = '0;
    logic [2*NP-1:0]   out_inv  = '0;
    logic [2*NP-1:0]   clk_out;
    logic              oe_a;
    logic              oe_b;

    int checks = 0;
    int errors = 0;

    always #4 pll_clk = ~pll_clk;   // 125 MHz
    always #10 ref_clk = ~ref_clk;

    clk_pair_sel #(.PAIRS_PER_BANK(PPB), .XW(XW)) i_clk_pair_sel (
        .pll_clk  (pll_clk),
        .ref_clk  (ref_clk),
        .rst      (rst),
        .pll_lock (pll_lock),
        .mode_sel (mode_sel),
        .div_x    (div_x),
        .pair_src (pair_src),
        .out_inv  (out_inv),
        .clk_out  (clk_out),
        .oe_a     (oe_a),
        .oe_b     (oe_b)
    );

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int divisor_of(input int code, input int xv);
        int xe;
        xe = (xv < 2) ? 2 : xv;
        case (code)
            1: return 1;
            2: return 2;
            3: return 3;
            4: return 4;
            5: return xe;
            6: return 2 * xe;
            default: return 1;
        endcase
    endfunction

    // R2: high for the first D half-cycles of every 2D half-cycle period
    function automatic logic wave(input int d, input int h);
        return ((h % (2 * d)) < d);
    endfunction

    task automatic wait_pos(input bit use_ref);
        if (use_ref) @(posedge ref_clk);
        else @(posedge pll_clk);
    endtask

    task automatic wait_neg(input bit use_ref);
        if (use_ref) @(negedge ref_clk);
        else @(negedge pll_clk);
    endtask

    task automatic check_all(input bit use_ref, input int xv, input int h);
        for (int p = 0; p < NP; p++) begin
            int code;
            code = int'(pair_src[3*p +: 3]);
            for (int j = 0; j < 2; j++) begin
                int    idx;
                string req;
                logic  exp;
                idx = 2 * p + j;
                exp = wave(divisor_of(code, xv), h) ^ out_inv[idx];
                if (use_ref)        req = "R8 R2";
                else if (code >= 5) req = "R6 R2";
                else                req = "R1 R2";
                if (out_inv[idx]) req = {req, " R5"};
                chk(req, clk_out[idx], exp,
                    $sformatf("pair %0d out %0d code %0d half %0d", p, j, code, h));
            end
            if (out_inv[2*p] == out_inv[2*p+1])
                chk("R10", clk_out[2*p+1], clk_out[2*p], $sformatf("pair %0d sides", p));
            for (int q = p + 1; q < NP; q++) begin
                if (pair_src[3*q +: 3] == pair_src[3*p +: 3] && out_inv[2*q] == out_inv[2*p])
                    chk("R10", clk_out[2*q], clk_out[2*p], $sformatf("pair %0d vs %0d", q, p));
            end
        end
    endtask

    task automatic sweep(input bit use_ref, input int xv, input logic [3*NP-1:0] codes,
                         input logic [2*NP-1:0] inv, input int ncyc);
        rst      = 1'b1;
        mode_sel = use_ref ? 2'b10 : 2'b11;
        div_x    = XW'(xv);
        pair_src = codes;
        out_inv  = inv;
        repeat (3) @(posedge ref_clk);
        @(posedge pll_clk);
        #2;
        chk("R9", oe_a, 1'b0, "oe_a in reset");
        chk("R9", oe_b, 1'b0, "oe_b in reset");
        for (int p = 0; p < NP; p++) begin
            if (int'(codes[3*p +: 3]) >= 2 && int'(codes[3*p +: 3]) <= 6)
                chk("R9", clk_out[2*p], inv[2*p], $sformatf("pair %0d level in reset", p));
        end
        wait_pos(use_ref);
        #1 rst = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            wait_pos(use_ref);
            #2 check_all(use_ref, xv, 2 * k);
            wait_neg(use_ref);
            #2 check_all(use_ref, xv, 2 * k + 1);
        end
        chk("R7", oe_a, 1'b1, "oe_a after sweep");
        chk("R7", oe_b, 1'b1, "oe_b after sweep");
    endtask

    initial begin
        // pair 0 sits in the least significant field
        sweep(1'b0, 3, {3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1}, 12'h000, 24);
        sweep(1'b0, 4, {3'd2, 3'd5, 3'd6, 3'd6, 3'd3, 3'd3}, 12'h600, 32);
        sweep(1'b0, 0, {3'd4, 3'd6, 3'd5, 3'd2, 3'd6, 3'd5}, 12'h000, 16);  // R6 clamp
        sweep(1'b0, 7, {3'd2, 3'd4, 3'd1, 3'd3, 3'd5, 3'd6}, 12'h0A5, 30);
        sweep(1'b1, 5, {3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1}, 12'h000, 24);
        sweep(1'b1, 2, {3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6}, 12'h30C, 16);

        // R3 and R4: reference pass-through and lock indicator
        pair_src = {3'd2, 3'd2, 3'd2, 3'd7, 3'd7, 3'd0};
        out_inv  = 12'b0000_0000_0110;
        for (int m = 0; m < 2; m++) begin
            mode_sel = (m == 0) ? 2'b11 : 2'b10;
            repeat (2) @(posedge pll_clk);
            for (int i = 0; i < 3; i++) begin
                @(posedge ref_clk);
                #2;
                chk("R3", clk_out[0], 1'b1, "ref high phase");
                chk("R3 R5", clk_out[1], 1'b0, "ref high phase inverted");
                @(negedge ref_clk);
                #2;
                chk("R3", clk_out[0], 1'b0, "ref low phase");
                chk("R3 R5", clk_out[1], 1'b1, "ref low phase inverted");
            end
        end
        @(negedge pll_clk);
        pll_lock = 1'b1;
        #1;
        chk("R4 R5", clk_out[2], 1'b0, "locked, inverted side");
        chk("R4", clk_out[3], 1'b1, "locked, plain side");
        chk("R4", clk_out[4], 1'b1, "locked, pair 2 side 0");
        chk("R4", clk_out[5], 1'b1, "locked, pair 2 side 1");
        pll_lock = 1'b0;
        #1;
        chk("R4 R5", clk_out[2], 1'b1, "unlocked, inverted side");
        chk("R4", clk_out[3], 1'b0, "unlocked, plain side");
        chk("R4", clk_out[4], 1'b0, "unlocked, pair 2 side 0");
        chk("R4", clk_out[5], 1'b0, "unlocked, pair 2 side 1");

        // R7: mode table, updated only at the PLL edge
        mode_sel = 2'b11;
        repeat (2) @(posedge pll_clk);
        begin
            logic pa;
            logic pb;
            pa = 1'b1;
            pb = 1'b1;
            for (int m = 0; m < 4; m++) begin
                @(posedge pll_clk);
                #2 mode_sel = 2'(m);
                #1;
                chk("R7", oe_a, pa, $sformatf("oe_a held before edge, mode %0d", m));
                chk("R7", oe_b, pb, $sformatf("oe_b held before edge, mode %0d", m));
                @(posedge pll_clk);
                #2;
                pa = (m != 0);
                pb = (m >= 2);
                chk("R7", oe_a, pa, $sformatf("oe_a mode %0d", m));
                chk("R7", oe_b, pb, $sformatf("oe_b mode %0d", m));
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule